// File: doc/BRIEF.md
# Single-Byte Serial Port Register Interface

This block is the processor-facing side of a simple asynchronous serial port that buffers exactly one byte in each direction. A two-location bus reaches it. Location 0 takes control writes and returns status on reads. Location 1 loads the outgoing byte on writes and returns the incoming byte on reads. There is no FIFO, so software polls the status flags before it touches the data location.

The serial shifter, bit-rate timing and framing are outside the block. Received bytes arrive on a valid-only input. The receive side applies no back-pressure: every byte is accepted, and a byte that arrives while the previous one is still unread raises overrun. The outgoing byte leaves on a valid/ready output. It is offered while pending and counts as taken on the clock edge where valid and ready are both high.

Per-direction enables in the control register decide whether a byte arrival or a transmit drain sets the interrupt flag. The flag drives the `irq` pin. A separate debug read port returns the same register contents as the bus with no side effects.

Top module: `serial_byte_port`

## Requirements
- R1: After reset, status reads 0x02 (only transmit-empty set), `irq` is low and `tx_valid` is low.
- R2: On the bus, location 0 is the control register on write and status on read; location 1 is the transmit byte on write and the received byte on read. Status bit 7 is the interrupt flag, bit 5 overrun, bit 1 transmit-empty and bit 0 receive-full.
- R3: A byte on `rx_valid` sets receive-full and becomes readable at location 1. A bus read of location 1 clears receive-full.
- R4: A byte arriving while receive-full is set and not being read in the same cycle sets overrun, and the newer byte replaces the old one. A bus read of location 1 clears overrun.
- R5: A bus write to location 1 makes the byte pending, so `tx_valid` goes high, `tx_data` holds the byte and transmit-empty clears. The byte stays until a cycle with `tx_ready` high, after which transmit-empty sets again.
- R6: With control bit 7 set, a received byte sets the interrupt flag and `irq` on the next edge.
- R7: With control bit 5 set, the interrupt flag sets when the pending byte is taken and the buffer is left empty. A data write alone does not set it, and neither does a take in the same cycle as a new write.
- R8: With the matching enable clear (for example control 0x00 or 0x02), receive and transmit events leave the interrupt flag clear.
- R9: A bus status read returns the current flag and then clears it, so `irq` falls on that edge. An enabled event in the same cycle keeps the flag set.
- R10: A debug read returns what a bus read of the same location would return and changes no state: it clears neither receive-full, overrun nor the interrupt flag.
- R11: A byte arriving in the same cycle as a bus read of location 1 is kept, leaves receive-full set and does not raise overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = control/status, 1 = data |
| bus_wdata | input | DATA_W | Bus write data |
| bus_rdata | output | DATA_W | Bus read data, combinational from current state |
| dbg_addr | input | 1 | Debug read location |
| dbg_rdata | output | DATA_W | Debug read data, no side effects |
| rx_valid | input | 1 | Received byte strobe, always accepted |
| rx_data | input | DATA_W | Received byte |
| tx_valid | output | 1 | Transmit byte pending |
| tx_ready | input | 1 | Transmitter takes the pending byte |
| tx_data | output | DATA_W | Pending transmit byte |
| irq | output | 1 | Interrupt request, follows the flag |

## Verification
Read data is combinational, so the bench samples `bus_rdata`, `dbg_rdata` and `tx_data` in the same cycle the access or take is driven, before the edge that applies its side effect. All flag, buffer and `irq` changes land one edge after the stimulus cycle. The bench drives each stimulus on a falling edge, lets one rising edge pass, and checks on the next falling edge. It also checks the same-cycle collisions (status read with an event, data read with an arrival, write with a take) in both of these sampling slots.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  localparam int STAT_IRQ  = 7;
  localparam int STAT_OVR  = 5;
  localparam int STAT_TXE  = 1;
  localparam int STAT_RXF  = 0;
  localparam int CTRL_RXIE = 7;
  localparam int CTRL_TXIE = 5;
  localparam logic LOC_CTRL = 1'b0;
  localparam logic LOC_DATA = 1'b1;
endpackage

// File: rtl/sbp_rx_hold.sv
module sbp_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              rd_take,
  output logic [DATA_W-1:0] held,
  output logic              full,
  output logic              ovr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
      full <= 1'b0;
      ovr  <= 1'b0;
    end else if (in_valid) begin
      held <= in_data;
      full <= 1'b1;
      if (full && !rd_take) ovr <= 1'b1;
      else if (rd_take)     ovr <= 1'b0;
    end else if (rd_take) begin
      full <= 1'b0;
      ovr  <= 1'b0;
    end
  end

  a_r4_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full && !rd_take) |=> ovr);
  a_r3_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && !in_valid) |=> (!full && !ovr));
  a_r11_byte_kept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (full && held == $past(in_data)));
endmodule

// File: rtl/sbp_tx_hold.sv
module sbp_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ready,
  output logic              pend,
  output logic [DATA_W-1:0] pend_data,
  output logic              drained
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      pend_data <= '0;
    end else if (wr) begin
      pend      <= 1'b1;
      pend_data <= wdata;
    end else if (pend && ready) begin
      pend <= 1'b0;
    end
  end

  assign drained = pend & ready & ~wr;

  a_r5_write_pends: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (pend && pend_data == $past(wdata)));
  a_r5_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !ready && !wr) |=> (pend && $stable(pend_data)));
  a_r5_take_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && ready && !wr) |=> !pend);
endmodule

// File: rtl/sbp_irq_ctrl.sv
module sbp_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic ctrl_rx_ie,
  input  logic ctrl_tx_ie,
  input  logic rx_evt,
  input  logic tx_evt,
  input  logic stat_rd,
  output logic flag
);
  logic rx_ie, tx_ie, set_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ie <= 1'b0;
      tx_ie <= 1'b0;
    end else if (ctrl_wr) begin
      rx_ie <= ctrl_rx_ie;
      tx_ie <= ctrl_tx_ie;
    end
  end

  assign set_now = (rx_evt & rx_ie) | (tx_evt & tx_ie);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (set_now)  flag <= 1'b1;
    else if (stat_rd)  flag <= 1'b0;
  end

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !rx_evt && !tx_evt) |=> !flag);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !rx_evt && !tx_evt) |=> !flag);
  a_r6_rx_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_evt && rx_ie) |=> flag);
  a_r7_tx_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_evt && tx_ie) |=> flag);
endmodule

// File: rtl/serial_byte_port.sv
module serial_byte_port
  import sbp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dbg_addr,
  output logic [DATA_W-1:0] dbg_rdata,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              irq
);
  logic cpu_rd, stat_rd, data_rd, ctrl_wr, data_wr;
  logic [DATA_W-1:0] rx_byte, status;
  logic rx_full, rx_ovr, tx_drained, flag;

  assign cpu_rd  = bus_sel & ~bus_wr;
  assign stat_rd = cpu_rd & (bus_addr == LOC_CTRL);
  assign data_rd = cpu_rd & (bus_addr == LOC_DATA);
  assign ctrl_wr = bus_sel & bus_wr & (bus_addr == LOC_CTRL);
  assign data_wr = bus_sel & bus_wr & (bus_addr == LOC_DATA);

  sbp_rx_hold #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .in_valid(rx_valid), .in_data(rx_data),
    .rd_take(data_rd), .held(rx_byte), .full(rx_full), .ovr(rx_ovr));

  sbp_tx_hold #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .wr(data_wr), .wdata(bus_wdata),
    .ready(tx_ready), .pend(tx_valid), .pend_data(tx_data),
    .drained(tx_drained));

  sbp_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
    .ctrl_rx_ie(bus_wdata[CTRL_RXIE]), .ctrl_tx_ie(bus_wdata[CTRL_TXIE]),
    .rx_evt(rx_valid), .tx_evt(tx_drained), .stat_rd(stat_rd), .flag(flag));

  always_comb begin
    status           = '0;
    status[STAT_IRQ] = flag;
    status[STAT_OVR] = rx_ovr;
    status[STAT_TXE] = ~tx_valid;
    status[STAT_RXF] = rx_full;
  end

  assign bus_rdata = (bus_addr == LOC_DATA) ? rx_byte : status;
  assign dbg_rdata = (dbg_addr == LOC_DATA) ? rx_byte : status;
  assign irq       = flag;

  a_r10_dbg_matches_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_addr == bus_addr) |-> (dbg_rdata == bus_rdata));
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !rx_valid && !tx_ready) |=> !irq);
endmodule

// File: tb/test_serial_byte_port.sv
module test_serial_byte_port;
  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_RX = 3'd2,
                         OP_TK = 3'd3, OP_DB = 3'd4, OP_IQ = 3'd5, OP_TV = 3'd6;
  typedef struct packed {
    logic [2:0] op;
    logic       addr;
    logic [7:0] data;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;
  localparam int NV = 34;
  localparam vec_t VT [NV] = '{
    '{OP_DB, 1'b0, 8'h00, 8'h02, 4'd1},  // R1 reset status
    '{OP_IQ, 1'b0, 8'h00, 8'h00, 4'd1},  // R1 irq low
    '{OP_RX, 1'b0, 8'h41, 8'h00, 4'd3},  // R3 arrival
    '{OP_DB, 1'b0, 8'h00, 8'h03, 4'd10}, // R10 debug status
    '{OP_DB, 1'b1, 8'h00, 8'h41, 4'd10}, // R10 debug data
    '{OP_RD, 1'b0, 8'h00, 8'h03, 4'd2},  // R2 status read, still full
    '{OP_RX, 1'b0, 8'h42, 8'h00, 4'd4},  // R4 second byte
    '{OP_DB, 1'b0, 8'h00, 8'h23, 4'd4},  // R4 overrun set
    '{OP_DB, 1'b1, 8'h00, 8'h42, 4'd10}, // R10 debug data no clear
    '{OP_DB, 1'b0, 8'h00, 8'h23, 4'd10}, // R10 overrun survives
    '{OP_RD, 1'b1, 8'h00, 8'h42, 4'd4},  // R4 newer byte kept
    '{OP_RD, 1'b0, 8'h00, 8'h02, 4'd4},  // R4 overrun cleared
    '{OP_WR, 1'b0, 8'h80, 8'h00, 4'd6},  // R6 rx enable
    '{OP_RX, 1'b0, 8'h55, 8'h00, 4'd6},
    '{OP_IQ, 1'b0, 8'h00, 8'h01, 4'd6},  // R6 irq set
    '{OP_RD, 1'b0, 8'h00, 8'h83, 4'd9},  // R9 read shows flag
    '{OP_IQ, 1'b0, 8'h00, 8'h00, 4'd9},  // R9 irq dropped
    '{OP_RD, 1'b0, 8'h00, 8'h03, 4'd9},
    '{OP_RD, 1'b1, 8'h00, 8'h55, 4'd3},  // R3 data read
    '{OP_WR, 1'b0, 8'h20, 8'h00, 4'd7},  // R7 tx enable
    '{OP_WR, 1'b1, 8'hA5, 8'h00, 4'd5},  // R5 load byte
    '{OP_TV, 1'b0, 8'h00, 8'h01, 4'd5},
    '{OP_IQ, 1'b0, 8'h00, 8'h00, 4'd7},  // R7 write alone no irq
    '{OP_DB, 1'b0, 8'h00, 8'h00, 4'd5},  // R5 tx not empty
    '{OP_TK, 1'b0, 8'h00, 8'hA5, 4'd5},  // R5 take
    '{OP_DB, 1'b0, 8'h00, 8'h82, 4'd7},  // R7 flag after drain
    '{OP_IQ, 1'b0, 8'h00, 8'h01, 4'd7},
    '{OP_RD, 1'b0, 8'h00, 8'h82, 4'd9},
    '{OP_WR, 1'b0, 8'h02, 8'h00, 4'd8},  // R8 both off
    '{OP_RX, 1'b0, 8'h11, 8'h00, 4'd8},
    '{OP_WR, 1'b1, 8'h22, 8'h00, 4'd8},
    '{OP_TK, 1'b0, 8'h00, 8'h22, 4'd8},
    '{OP_DB, 1'b0, 8'h00, 8'h03, 4'd8},  // R8 flag stays clear
    '{OP_RD, 1'b1, 8'h00, 8'h11, 4'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0, bus_addr = 0, dbg_addr = 0;
  logic rx_valid = 0, tx_ready = 0;
  logic [7:0] bus_wdata = 0, rx_data = 0;
  logic [7:0] bus_rdata, dbg_rdata, tx_data;
  logic tx_valid, irq;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  serial_byte_port #(.DATA_W(8)) i_serial_byte_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dbg_addr(dbg_addr), .dbg_rdata(dbg_rdata), .rx_valid(rx_valid),
    .rx_data(rx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .irq(irq));

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle();
    bus_sel = 0; bus_wr = 0; rx_valid = 0; tx_ready = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      idle();
      case (VT[i].op)
        OP_WR: begin bus_sel = 1; bus_wr = 1; bus_addr = VT[i].addr; bus_wdata = VT[i].data; end
        OP_RD: begin bus_sel = 1; bus_addr = VT[i].addr; end
        OP_RX: begin rx_valid = 1; rx_data = VT[i].data; end
        OP_TK: tx_ready = 1;
        OP_DB: dbg_addr = VT[i].addr;
        default: ;
      endcase
      #2;
      case (VT[i].op)
        OP_RD: check(int'(VT[i].req), bus_rdata, VT[i].exp);
        OP_TK: check(int'(VT[i].req), tx_data, VT[i].exp);
        OP_DB: check(int'(VT[i].req), dbg_rdata, VT[i].exp);
        OP_IQ: check(int'(VT[i].req), {7'd0, irq}, VT[i].exp);
        OP_TV: check(int'(VT[i].req), {7'd0, tx_valid}, VT[i].exp);
        default: ;
      endcase
    end

    // R9: status read colliding with an enabled arrival keeps the flag
    @(negedge clk); idle();
    bus_sel = 1; bus_wr = 1; bus_addr = 0; bus_wdata = 8'h80;
    @(negedge clk); idle();
    bus_sel = 1; bus_addr = 0; rx_valid = 1; rx_data = 8'h66;
    #2 check(9, bus_rdata, 8'h02);
    @(negedge clk); idle(); dbg_addr = 0;
    #2 check(9, {7'd0, irq}, 8'h01);
    check(9, dbg_rdata, 8'h83);

    // R11: arrival in the same cycle as a data read
    @(negedge clk); idle();
    bus_sel = 1; bus_addr = 1; rx_valid = 1; rx_data = 8'h77;
    #2 check(11, bus_rdata, 8'h66);
    @(negedge clk); idle(); dbg_addr = 0;
    #2 check(11, dbg_rdata, 8'h83);
    dbg_addr = 1;
    #1 check(11, dbg_rdata, 8'h77);

    // R7: take colliding with a new write raises no interrupt
    @(negedge clk); idle(); bus_sel = 1; bus_addr = 0;
    #2 check(9, bus_rdata, 8'h83);
    @(negedge clk); idle();
    bus_sel = 1; bus_wr = 1; bus_addr = 0; bus_wdata = 8'h20;
    @(negedge clk); idle();
    bus_sel = 1; bus_wr = 1; bus_addr = 1; bus_wdata = 8'hA1;
    @(negedge clk); idle();
    bus_sel = 1; bus_wr = 1; bus_addr = 1; bus_wdata = 8'hB2; tx_ready = 1;
    #2 check(7, tx_data, 8'hA1);
    @(negedge clk); idle();
    #2 check(7, {7'd0, irq}, 8'h00);
    check(5, {7'd0, tx_valid}, 8'h01);
    check(5, tx_data, 8'hB2);
    @(negedge clk); idle(); tx_ready = 1;
    @(negedge clk); idle();
    #2 check(7, {7'd0, irq}, 8'h01);

    // R1: reset mid-run
    @(negedge clk); idle(); rst_n = 0;
    @(negedge clk); rst_n = 1; dbg_addr = 0;
    #2 check(1, dbg_rdata, 8'h02);
    check(1, {7'd0, irq}, 8'h00);
    check(1, {7'd0, tx_valid}, 8'h00);

    finish_run();
  end
endmodule